// File: doc/BRIEF.md
# Graphics DRAM Mode and Extended-Mode Register Responder

This block models the device side of a graphics DRAM's configuration path. It watches decoded command strobes and the address bus. It keeps the settings that mode-set and extended-mode-set commands program: the write-recovery count, the data termination choice, the output driver strength choice and the DLL enable. It also models the settling time the DLL needs before reads are allowed, and raises a read-ready flag once that time has passed.

Bit 10 of an extended-mode-set command switches the low data byte into an identification mode. After a programmable turn-on delay, the block drives a fixed byte that carries a vendor code and a revision code. It keeps driving that byte until an extended-mode-set command with bit 10 clear arrives. After a separate turn-off delay, the byte goes back to all ones and the output enable drops. Any other command issued while identification mode is active breaks the usage rule. The block records this in a sticky flag so that a controller model or a bench can detect the misuse.

Top module: `emr_responder`

## Requirements
- R1: After reset the outputs are wr_cycles = 4, term_sel = 2'b00 (off), drv_sel = 2'b00 (auto-calibrated), dll_en = 1, dq_oe = 0, dq_out = 8'hFF and proto_err = 0.
- R2: A mode-set command (cmd_kind = 3'd0) loads wr_cycles with addr[6:4] + 4, giving counts 4 to 11, one cycle after the capturing edge. The other fields do not change.
- R3: An extended-mode-set command (cmd_kind = 3'd1) loads term_sel from addr[1:0] and drv_sel from addr[3:2]. The term_sel encodings are 00 = off, 01 = ZQ/4 and 10 = ZQ/2; code 11 is stored as 00 (off). The drv_sel encodings are 00 = auto ZQ/6, 01 = 30 ohm, 10 = 40 ohm and 11 = 45 ohm.
- R4: In an extended-mode-set command, addr[6] = 1 clears dll_en and addr[6] = 0 sets it. A self-refresh exit (cmd_kind = 3'd3) sets dll_en.
- R5: rd_ready is 0 while dll_en is 0. After reset release it rises exactly DLL_LOCK cycles later. After an enabling command (a self-refresh exit, or an extended-mode-set that enables a disabled DLL) it rises DLL_LOCK cycles after the cycle in which that command takes effect.
- R6: An extended-mode-set command with addr[10] = 1 makes dq_oe = 1 and dq_out = 8'h32 (vendor code 4'b0010 on bits 3:0, revision 4'b0011 on bits 7:4). Both appear ID_ON cycles after the capturing edge.
- R7: An extended-mode-set command with addr[10] = 0 during identification mode drops dq_oe ID_OFF cycles after the capturing edge. Whenever dq_oe is 0, dq_out is 8'hFF.
- R8: Any command other than the disabling extended-mode-set, issued while identification mode is active, sets proto_err. proto_err stays set until reset.
- R9: While cmd_vld is 0, cmd_kind and addr have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | Command strobe |
| cmd_kind | input | 3 | Command type: 0 mode-set, 1 extended-mode-set, 2 read, 3 self-refresh exit, others generic |
| addr | input | ADDR_W | Address bus carrying the settings |
| wr_cycles | output | 4 | Write-recovery count in clocks |
| term_sel | output | 2 | Termination choice |
| drv_sel | output | 2 | Driver impedance choice |
| dll_en | output | 1 | DLL enabled |
| rd_ready | output | 1 | DLL settled, reads allowed |
| dq_out | output | 8 | Low data byte |
| dq_oe | output | 1 | Low data byte output enable |
| proto_err | output | 1 | Sticky identification-mode misuse flag |

## Verification
If the identification state machine holds a wrong state, dq_oe turns on or off on the wrong cycle, so the turn-on and turn-off edges are checked on the exact cycle and on the cycle just before it. A lock counter that restarts or saturates wrongly moves the rd_ready edge, so that edge is checked against reset release, a self-refresh exit and an enable after a disable. A decode slip in the field registers shows on the next cycle as a wrong wr_cycles, term_sel or drv_sel. A missed violation shows as proto_err staying low one cycle after the offending command.

// File: rtl/emr_pkg.sv
package emr_pkg;
  localparam logic [2:0] CMD_MODE_SET = 3'd0;
  localparam logic [2:0] CMD_EXT_SET  = 3'd1;
  localparam logic [2:0] CMD_READ     = 3'd2;
  localparam logic [2:0] CMD_SR_EXIT  = 3'd3;

  localparam logic [3:0] VENDOR_CODE = 4'b0010;
  localparam logic [3:0] REVISION    = 4'b0011;

  // write recovery: 3-bit code maps to 4..11 clocks
  function automatic logic [3:0] wr_from_code(input logic [2:0] code);
    return {1'b0, code} + 4'd4;
  endfunction

  // termination: the reserved code falls back to off
  function automatic logic [1:0] term_from_code(input logic [1:0] code);
    return (code == 2'b11) ? 2'b00 : code;
  endfunction

  function automatic logic [7:0] id_byte();
    return {REVISION, VENDOR_CODE};
  endfunction
endpackage

// File: rtl/emr_field_regs.sv
module emr_field_regs
  import emr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic       ext_wr,
  input  logic       sr_exit,
  input  logic [6:0] fld,
  output logic [3:0] wr_cycles,
  output logic [1:0] term_sel,
  output logic [1:0] drv_sel,
  output logic       dll_en,
  output logic       dll_restart
);
  localparam int DLL_OFF_BIT = 6;

  logic ext_dll_on;
  assign ext_dll_on  = ext_wr && !fld[DLL_OFF_BIT];
  assign dll_restart = sr_exit || (ext_dll_on && !dll_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_cycles <= wr_from_code(3'd0);
      term_sel  <= 2'b00;
      drv_sel   <= 2'b00;
      dll_en    <= 1'b1;
    end else begin
      if (mode_wr) wr_cycles <= wr_from_code(fld[6:4]);
      if (ext_wr) begin
        term_sel <= term_from_code(fld[1:0]);
        drv_sel  <= fld[3:2];
        dll_en   <= !fld[DLL_OFF_BIT];
      end
      if (sr_exit) dll_en <= 1'b1;
    end
  end
endmodule

// File: rtl/emr_dll_lock.sv
module emr_dll_lock #(
  parameter int DLL_LOCK = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic dll_en,
  output logic rd_ready
);
  localparam int CW = $clog2(DLL_LOCK + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DLL_LOCK);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt <= '0;
    else if (restart)                 cnt <= '0;
    else if (!dll_en)                 cnt <= '0;
    else if (cnt != LIMIT)            cnt <= cnt + 1'b1;
  end

  assign rd_ready = dll_en && (cnt == LIMIT);
endmodule

// File: rtl/emr_id_ctrl.sv
module emr_id_ctrl
  import emr_pkg::*;
#(
  parameter int ID_ON  = 4,
  parameter int ID_OFF = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       id_start,
  input  logic       id_stop,
  output logic       id_mode,
  output logic [7:0] dq_out,
  output logic       dq_oe
);
  localparam int MAXD = (ID_ON > ID_OFF) ? ID_ON : ID_OFF;
  localparam int TW   = $clog2(MAXD + 1);

  typedef enum logic [1:0] {ID_IDLE, ID_WAIT_ON, ID_ACTIVE, ID_WAIT_OFF} id_state_t;

  id_state_t     st;
  logic [TW-1:0] tmr;
  logic          drive;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ID_IDLE;
      tmr   <= '0;
      drive <= 1'b0;
    end else if (id_start && (st == ID_IDLE || st == ID_WAIT_OFF)) begin
      st  <= ID_WAIT_ON;
      tmr <= TW'(ID_ON);
    end else if (id_stop && (st == ID_WAIT_ON || st == ID_ACTIVE)) begin
      st  <= ID_WAIT_OFF;
      tmr <= TW'(ID_OFF);
    end else begin
      case (st)
        ID_WAIT_ON: begin
          if (tmr <= 1) begin
            st    <= ID_ACTIVE;
            drive <= 1'b1;
          end
          tmr <= tmr - 1'b1;
        end
        ID_WAIT_OFF: begin
          if (tmr <= 1) begin
            st    <= ID_IDLE;
            drive <= 1'b0;
          end
          tmr <= tmr - 1'b1;
        end
        default: tmr <= '0;
      endcase
    end
  end

  assign id_mode = (st == ID_WAIT_ON) || (st == ID_ACTIVE);
  assign dq_oe   = drive;
  assign dq_out  = drive ? id_byte() : 8'hFF;
endmodule

// File: rtl/emr_responder.sv
module emr_responder
  import emr_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int ID_ON    = 4,
  parameter int ID_OFF   = 3,
  parameter int DLL_LOCK = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  logic [2:0]        cmd_kind,
  input  logic [ADDR_W-1:0] addr,
  output logic [3:0]        wr_cycles,
  output logic [1:0]        term_sel,
  output logic [1:0]        drv_sel,
  output logic              dll_en,
  output logic              rd_ready,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  output logic              proto_err
);
  localparam int ID_BIT = 10;

  // decoded command events, named for the checker
  logic mode_wr, ext_wr, sr_exit, id_start, id_stop;
  logic id_mode, violate_evt, dll_restart;
  logic unused_addr;

  assign mode_wr  = cmd_vld && (cmd_kind == CMD_MODE_SET);
  assign ext_wr   = cmd_vld && (cmd_kind == CMD_EXT_SET);
  assign sr_exit  = cmd_vld && (cmd_kind == CMD_SR_EXIT);
  assign id_start = ext_wr && addr[ID_BIT];
  assign id_stop  = ext_wr && !addr[ID_BIT];
  assign unused_addr = ^{addr[ADDR_W-1:ID_BIT+1], addr[ID_BIT-1:7]};

  assign violate_evt = cmd_vld && id_mode && !id_stop;

  emr_field_regs u_fields (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .ext_wr(ext_wr),
    .sr_exit(sr_exit), .fld(addr[6:0]), .wr_cycles(wr_cycles),
    .term_sel(term_sel), .drv_sel(drv_sel), .dll_en(dll_en),
    .dll_restart(dll_restart)
  );

  emr_dll_lock #(.DLL_LOCK(DLL_LOCK)) u_lock (
    .clk(clk), .rst_n(rst_n), .restart(dll_restart), .dll_en(dll_en),
    .rd_ready(rd_ready)
  );

  emr_id_ctrl #(.ID_ON(ID_ON), .ID_OFF(ID_OFF)) u_id (
    .clk(clk), .rst_n(rst_n), .id_start(id_start), .id_stop(id_stop),
    .id_mode(id_mode), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           proto_err <= 1'b0;
    else if (violate_evt) proto_err <= 1'b1;
  end
endmodule

// File: rtl/emr_responder_chk.sv
module emr_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sr_exit,
  input logic       id_mode,
  input logic       violate_evt,
  input logic       dll_en,
  input logic       rd_ready,
  input logic [7:0] dq_out,
  input logic       dq_oe,
  input logic       proto_err
);
  // R6
  id_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> dq_out == 8'h32);
  // R7
  bus_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> dq_out == 8'hFF);
  // R5
  ready_needs_dll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> dll_en);
  // R5
  srx_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit |=> !rd_ready);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
  // R8
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (violate_evt && id_mode) |=> proto_err);
endmodule

bind emr_responder emr_responder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sr_exit(sr_exit), .id_mode(id_mode),
  .violate_evt(violate_evt), .dll_en(dll_en), .rd_ready(rd_ready),
  .dq_out(dq_out), .dq_oe(dq_oe), .proto_err(proto_err)
);

// File: tb/emr_responder_tb_top.sv
module emr_responder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ID_ON  = 4;
  localparam int ID_OFF = 3;
  localparam int LOCK   = 1000;

  typedef enum int {S_WR, S_TERM, S_DRV, S_DLL, S_RDY, S_DQ, S_OE, S_ERR} sig_t;
  typedef struct {
    int    due;
    sig_t  sel;
    int    exp;
    string req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_vld = 1'b0;
  logic [2:0]  cmd_kind = 3'd0;
  logic [11:0] addr = '0;
  logic [3:0]  wr_cycles;
  logic [1:0]  term_sel, drv_sel;
  logic        dll_en, rd_ready, dq_oe, proto_err;
  logic [7:0]  dq_out;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int last_cmd = 0;
  bit done = 1'b0;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  emr_responder #(.ID_ON(ID_ON), .ID_OFF(ID_OFF), .DLL_LOCK(LOCK)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_kind(cmd_kind),
    .addr(addr), .wr_cycles(wr_cycles), .term_sel(term_sel),
    .drv_sel(drv_sel), .dll_en(dll_en), .rd_ready(rd_ready),
    .dq_out(dq_out), .dq_oe(dq_oe), .proto_err(proto_err)
  );

  function automatic int get_sig(sig_t s);
    case (s)
      S_WR:   return int'(wr_cycles);
      S_TERM: return int'(term_sel);
      S_DRV:  return int'(drv_sel);
      S_DLL:  return int'(dll_en);
      S_RDY:  return int'(rd_ready);
      S_DQ:   return int'(dq_out);
      S_OE:   return int'(dq_oe);
      default: return int'(proto_err);
    endcase
  endfunction

  task automatic expect_at(int due, sig_t sel, int exp, string req);
    item_t it;
    it.due = due; it.sel = sel; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  // monitor: compare every item that falls due on this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        int act;
        act = get_sig(sb[i].sel);
        checks++;
        if (act !== sb[i].exp) begin
          fails++;
          $display("FAIL %s sig=%s cyc=%0d actual=%0h expected=%0h",
                   sb[i].req, sb[i].sel.name(), cyc, act, sb[i].exp);
        end
        sb.delete(i);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    last_cmd = cyc;
  endtask

  task automatic issue(logic [2:0] kind, logic [11:0] a);
    @(negedge clk);
    cmd_vld = 1'b1; cmd_kind = kind; addr = a;
    last_cmd = cyc;
    @(negedge clk);
    cmd_vld = 1'b0; cmd_kind = 3'd7; addr = 12'hFFF;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int n;
    do_reset();
    n = last_cmd;
    // R1 reset defaults
    expect_at(n + 1, S_WR, 4, "R1");
    expect_at(n + 1, S_TERM, 0, "R1");
    expect_at(n + 1, S_DRV, 0, "R1");
    expect_at(n + 1, S_DLL, 1, "R1");
    expect_at(n + 1, S_OE, 0, "R1");
    expect_at(n + 1, S_DQ, 8'hFF, "R1");
    expect_at(n + 1, S_ERR, 0, "R1");
    // R5 lock after reset release
    expect_at(n + LOCK - 1, S_RDY, 0, "R5");
    expect_at(n + LOCK, S_RDY, 1, "R5");

    // R2 mode-set, code 5 -> 9, code 7 -> 11
    issue(3'd0, 12'h050);
    expect_at(last_cmd + 1, S_WR, 9, "R2");
    expect_at(last_cmd + 1, S_TERM, 0, "R2");
    issue(3'd0, 12'h070);
    expect_at(last_cmd + 1, S_WR, 11, "R2");

    // R9 strobe low: nothing changes
    @(negedge clk);
    cmd_kind = 3'd0; addr = 12'h000;
    n = cyc;
    expect_at(n + 2, S_WR, 11, "R9");
    @(negedge clk);
    cmd_kind = 3'd1; addr = 12'h44F;
    expect_at(n + 3, S_DLL, 1, "R9");
    expect_at(n + 3, S_OE, 0, "R9");
    expect_at(n + 3, S_TERM, 0, "R9");
    @(negedge clk);
    cmd_kind = 3'd7; addr = 12'hFFF;

    // R3 termination / driver
    issue(3'd1, 12'h009);
    expect_at(last_cmd + 1, S_TERM, 1, "R3");
    expect_at(last_cmd + 1, S_DRV, 2, "R3");
    issue(3'd1, 12'h00F);
    expect_at(last_cmd + 1, S_TERM, 0, "R3");
    expect_at(last_cmd + 1, S_DRV, 3, "R3");
    expect_at(last_cmd + 1, S_WR, 11, "R3");

    idle(LOCK);

    // R6 identification on, with term = ZQ/2 and driver 30 ohm
    issue(3'd1, 12'h406);
    n = last_cmd;
    expect_at(n + 1, S_TERM, 2, "R3");
    expect_at(n + 1, S_DRV, 1, "R3");
    expect_at(n + ID_ON, S_OE, 0, "R6");
    expect_at(n + ID_ON, S_DQ, 8'hFF, "R6");
    expect_at(n + ID_ON + 1, S_OE, 1, "R6");
    expect_at(n + ID_ON + 1, S_DQ, 8'h32, "R6");
    idle(ID_ON + 4);
    // R7 identification off
    issue(3'd1, 12'h006);
    n = last_cmd;
    expect_at(n + ID_OFF, S_OE, 1, "R7");
    expect_at(n + ID_OFF + 1, S_OE, 0, "R7");
    expect_at(n + ID_OFF + 1, S_DQ, 8'hFF, "R7");
    expect_at(n + ID_OFF + 1, S_ERR, 0, "R8");
    idle(ID_OFF + 3);

    // R8 read while identification active
    issue(3'd2, 12'h000);
    expect_at(last_cmd + 1, S_ERR, 0, "R8");
    issue(3'd1, 12'h400);
    idle(ID_ON + 2);
    issue(3'd2, 12'h000);
    expect_at(last_cmd + 1, S_ERR, 1, "R8");
    issue(3'd1, 12'h000);
    expect_at(last_cmd + ID_OFF + 4, S_ERR, 1, "R8");
    idle(ID_OFF + 6);
    do_reset();
    expect_at(last_cmd + 1, S_ERR, 0, "R8");
    expect_at(last_cmd + 1, S_WR, 4, "R1");
    idle(3);

    // R4 / R5 disable then enable via extended set
    issue(3'd1, 12'h040);
    expect_at(last_cmd + 1, S_DLL, 0, "R4");
    expect_at(last_cmd + 1, S_RDY, 0, "R5");
    idle(LOCK + 5);
    expect_at(cyc + 1, S_RDY, 0, "R5");
    idle(2);
    issue(3'd1, 12'h000);
    n = last_cmd;
    expect_at(n + 1, S_DLL, 1, "R4");
    expect_at(n + LOCK, S_RDY, 0, "R5");
    expect_at(n + LOCK + 1, S_RDY, 1, "R5");
    idle(LOCK + 4);

    // R4 / R5 self-refresh exit restarts the lock period
    issue(3'd1, 12'h040);
    issue(3'd3, 12'h000);
    n = last_cmd;
    expect_at(n + 1, S_DLL, 1, "R4");
    expect_at(n + 1, S_RDY, 0, "R5");
    expect_at(n + LOCK, S_RDY, 0, "R5");
    expect_at(n + LOCK + 1, S_RDY, 1, "R5");
    idle(LOCK + 4);

    if (sb.size() != 0) begin
      fails += sb.size();
      checks += sb.size();
      $display("FAIL scoreboard items never due: actual=%0d expected=0", sb.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule